// File: doc/BRIEF.md
# Half-Warp Constant Read Serializer

This block takes one constant-memory read issued by a 32-lane warp and turns it into a sequence of single-address lookups to a constant cache. Each lane supplies an address and an active bit. The lanes are handled as two independent groups of sixteen. The low group (lanes 0 to 15) is handled completely before the high group (lanes 16 to 31). Within a group, every distinct address used by an active lane costs exactly one cache lookup. The word that comes back is written to every active lane of that group that asked for the same address. A group whose lanes all use one address is therefore served in a single lookup, and a group with sixteen different addresses takes sixteen.

Only one cache lookup is in flight at any time, so a miss only stretches the wait for that lookup. When both groups are finished, the block presents the whole 32-lane result together with the number of lookups it made. Inactive lanes read back as zero.

The controller has five states. IDLE accepts a warp and moves to SCAN. SCAN picks the next address: if it finds one it goes to ISSUE. If the low group is exhausted, it switches to the high group and stays in SCAN. If the high group is exhausted, it goes to DONE. ISSUE moves to WAIT once the cache accepts the lookup. WAIT returns to SCAN when the response arrives. DONE returns to IDLE after one cycle.

Top module: `hcs_const_splitter`

## Requirements
- R1: After reset, `req_ready` is 1, `cache_req_valid` is 0 and `done_valid` is 0.
- R2: No lookup for a high-group lane (16 to 31) is issued while any active low-group lane (0 to 15) is still unserved.
- R3: Within a group, distinct addresses are issued in order of the lowest-numbered active lane that uses each one.
- R4: Each group issues exactly one lookup per distinct address among its active lanes. The same address used in both groups is looked up twice.
- R5: Every active lane receives the word returned for its own address, including lanes that share an address with an earlier lane.
- R6: An inactive lane causes no lookup, and its result lane reads 0.
- R7: A group with no active lanes issues no lookup. A warp with no active lanes completes with a count of 0.
- R8: At most one lookup is outstanding. No new request is raised between acceptance and response. A request that is not accepted keeps its valid and address unchanged.
- R9: Completion is a single-cycle `done_valid` pulse. `done_count` equals the number of lookups issued. `req_ready` is 0 from acceptance until that pulse.
- R10: Results are correct whatever the response latency, whether short (cache hit) or long (miss).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Warp read offered |
| req_ready | output | 1 | Block idle and able to take a warp |
| req_mask | input | LANES | Per-lane active bits |
| req_addr | input | LANES*ADDR_W | Per-lane addresses; lane i occupies bits i*ADDR_W upward |
| cache_req_valid | output | 1 | Lookup request to the constant cache |
| cache_req_ready | input | 1 | Cache accepts the lookup |
| cache_req_addr | output | ADDR_W | Lookup address |
| cache_rsp_valid | input | 1 | Lookup word returned |
| cache_rsp_data | input | DATA_W | Returned word |
| done_valid | output | 1 | Warp result valid (one cycle) |
| done_data | output | LANES*DATA_W | Per-lane results; lane i occupies bits i*DATA_W upward |
| done_count | output | $clog2(LANES+1) | Number of lookups issued for the warp |

## Verification
The hardest case to reach from the ports is a lookup order that differs from sorted address order, combined with duplicates spread across both groups and holes in the active mask. The stimulus builds address patterns that fall as the lane number rises. It repeats the same addresses in both groups, mixes short and long response latencies by address parity, and withholds `cache_req_ready` on a rotating pattern, so that stalled requests and late responses both occur while lanes sharing an address wait for one broadcast.

// File: rtl/hcs_pkg.sv
package hcs_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SCAN,
        ST_ISSUE,
        ST_WAIT,
        ST_DONE
    } hcs_state_t;
endpackage

// File: rtl/hcs_lane_pick.sv
module hcs_lane_pick #(
    parameter int LANES_H = 16,
    parameter int ADDR_W  = 16
) (
    input  logic [LANES_H-1:0]        pend,
    input  logic [LANES_H*ADDR_W-1:0] addr,
    output logic                      found,
    output logic [ADDR_W-1:0]         pick_addr,
    output logic [LANES_H-1:0]        match
);
    localparam int IDX_W = (LANES_H > 1) ? $clog2(LANES_H) : 1;

    logic [IDX_W-1:0] idx;

    // lowest pending lane wins
    always_comb begin
        idx = '0;
        for (int i = LANES_H - 1; i >= 0; i--) begin
            if (pend[i]) idx = IDX_W'(i);
        end
    end

    assign found     = |pend;
    assign pick_addr = addr[idx*ADDR_W +: ADDR_W];

    // every pending lane that shares the picked address
    generate
        for (genvar j = 0; j < LANES_H; j++) begin : g_match
            assign match[j] = pend[j] && (addr[j*ADDR_W +: ADDR_W] == pick_addr);
        end
    endgenerate
endmodule

// File: rtl/hcs_result_bank.sv
module hcs_result_bank #(
    parameter int LANES  = 32,
    parameter int DATA_W = 32
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      clear,
    input  logic                      wr_en,
    input  logic [LANES-1:0]          wr_mask,
    input  logic [DATA_W-1:0]         wr_data,
    output logic [LANES*DATA_W-1:0]   rd_data
);
    generate
        for (genvar k = 0; k < LANES; k++) begin : g_lane
            logic [DATA_W-1:0] word_q;
            always_ff @(posedge clk) begin
                if (!rst_n || clear) begin
                    word_q <= '0;
                end else if (wr_en && wr_mask[k]) begin
                    word_q <= wr_data;
                end
            end
            assign rd_data[k*DATA_W +: DATA_W] = word_q;
        end
    endgenerate
endmodule

// File: rtl/hcs_const_splitter.sv
module hcs_const_splitter
    import hcs_pkg::*;
#(
    parameter int LANES  = 32,
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      req_valid,
    output logic                      req_ready,
    input  logic [LANES-1:0]          req_mask,
    input  logic [LANES*ADDR_W-1:0]   req_addr,
    output logic                      cache_req_valid,
    input  logic                      cache_req_ready,
    output logic [ADDR_W-1:0]         cache_req_addr,
    input  logic                      cache_rsp_valid,
    input  logic [DATA_W-1:0]         cache_rsp_data,
    output logic                      done_valid,
    output logic [LANES*DATA_W-1:0]   done_data,
    output logic [$clog2(LANES+1)-1:0] done_count
);
    localparam int HALF  = LANES / 2;
    localparam int CNT_W = $clog2(LANES + 1);

    hcs_state_t state_q, state_d;

    logic [LANES-1:0]        pend_q;
    logic [LANES-1:0]        mask_q;
    logic [LANES*ADDR_W-1:0] addr_q;
    logic                    half_q;
    logic [ADDR_W-1:0]       cur_addr_q;
    logic [LANES-1:0]        cur_match_q;
    logic [CNT_W-1:0]        cnt_q;

    logic              found_h   [2];
    logic [ADDR_W-1:0] pick_h    [2];
    logic [HALF-1:0]   match_h   [2];

    generate
        for (genvar g = 0; g < 2; g++) begin : g_half
            hcs_lane_pick #(
                .LANES_H (HALF),
                .ADDR_W  (ADDR_W)
            ) u_pick (
                .pend      (pend_q[g*HALF +: HALF]),
                .addr      (addr_q[g*HALF*ADDR_W +: HALF*ADDR_W]),
                .found     (found_h[g]),
                .pick_addr (pick_h[g]),
                .match     (match_h[g])
            );
        end
    endgenerate

    logic              sel_found;
    logic [ADDR_W-1:0] sel_addr;
    logic [LANES-1:0]  sel_match;

    always_comb begin
        if (half_q) begin
            sel_found = found_h[1];
            sel_addr  = pick_h[1];
            sel_match = {match_h[1], {HALF{1'b0}}};
        end else begin
            sel_found = found_h[0];
            sel_addr  = pick_h[0];
            sel_match = {{HALF{1'b0}}, match_h[0]};
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (req_valid) state_d = ST_SCAN;
            ST_SCAN: begin
                if (sel_found)    state_d = ST_ISSUE;
                else if (!half_q) state_d = ST_SCAN;
                else              state_d = ST_DONE;
            end
            ST_ISSUE: if (cache_req_ready) state_d = ST_WAIT;
            ST_WAIT:  if (cache_rsp_valid) state_d = ST_SCAN;
            ST_DONE:  state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q      <= '0;
            mask_q      <= '0;
            addr_q      <= '0;
            half_q      <= 1'b0;
            cur_addr_q  <= '0;
            cur_match_q <= '0;
            cnt_q       <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (req_valid) begin
                        addr_q <= req_addr;
                        mask_q <= req_mask;
                        pend_q <= req_mask;
                        half_q <= 1'b0;
                        cnt_q  <= '0;
                    end
                end
                ST_SCAN: begin
                    if (sel_found) begin
                        cur_addr_q  <= sel_addr;
                        cur_match_q <= sel_match;
                    end else if (!half_q) begin
                        half_q <= 1'b1;
                    end
                end
                ST_ISSUE: begin
                    if (cache_req_ready) cnt_q <= cnt_q + 1'b1;
                end
                ST_WAIT: begin
                    if (cache_rsp_valid) pend_q <= pend_q & ~cur_match_q;
                end
                ST_DONE: ;
                default: ;
            endcase
        end
    end

    hcs_result_bank #(
        .LANES  (LANES),
        .DATA_W (DATA_W)
    ) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   ((state_q == ST_IDLE) && req_valid),
        .wr_en   ((state_q == ST_WAIT) && cache_rsp_valid),
        .wr_mask (cur_match_q),
        .wr_data (cache_rsp_data),
        .rd_data (done_data)
    );

    // outputs
    always_comb begin
        req_ready       = 1'b0;
        cache_req_valid = 1'b0;
        done_valid      = 1'b0;
        unique case (state_q)
            ST_IDLE:  req_ready       = 1'b1;
            ST_ISSUE: cache_req_valid = 1'b1;
            ST_DONE:  done_valid      = 1'b1;
            default:  ;
        endcase
    end
    assign cache_req_addr = cur_addr_q;
    assign done_count     = cnt_q;

    // R8: a stalled request holds
    p_hold_req_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cache_req_valid && !cache_req_ready |=> cache_req_valid && $stable(cache_req_addr));

    // R8: nothing new right after an accepted lookup
    p_single_out_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cache_req_valid && cache_req_ready |=> !cache_req_valid);

    // R2: while low lanes pend, the lookup in flight targets low lanes only
    p_lower_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAIT) && (|pend_q[HALF-1:0]) |-> (cur_match_q[LANES-1:HALF] == '0));

    // R5: broadcast set is non-empty and only covers unserved lanes
    p_match_sane_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ISSUE) |-> (cur_match_q != '0) && ((cur_match_q & ~pend_q) == '0));

    // R6: unserved lanes are always active lanes and never reappear
    p_pend_in_mask_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE) |-> ((pend_q & ~mask_q) == '0));
    p_pend_shrinks_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE) |=> ((pend_q & ~$past(pend_q)) == '0));

    // R4: never more lookups than active lanes
    p_count_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        done_valid |-> (done_count <= CNT_W'($countones(mask_q))));

    // R9: single-cycle completion, then idle
    p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done_valid |=> !done_valid && req_ready);
endmodule

// File: tb/hcs_const_splitter_test.sv
`timescale 1ns/1ps
module hcs_const_splitter_test;
    localparam int L  = 32;
    localparam int AW = 16;
    localparam int DW = 32;
    localparam int CW = $clog2(L + 1);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic req_ready;
    logic [L-1:0] req_mask = '0;
    logic [L*AW-1:0] req_addr = '0;
    logic cache_req_valid;
    logic cache_req_ready = 1'b0;
    logic [AW-1:0] cache_req_addr;
    logic cache_rsp_valid = 1'b0;
    logic [DW-1:0] cache_rsp_data = '0;
    logic done_valid;
    logic [L*DW-1:0] done_data;
    logic [CW-1:0] done_count;

    always #2.5 clk = ~clk;

    hcs_const_splitter #(.LANES(L), .ADDR_W(AW), .DATA_W(DW)) uut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_mask(req_mask), .req_addr(req_addr),
        .cache_req_valid(cache_req_valid), .cache_req_ready(cache_req_ready),
        .cache_req_addr(cache_req_addr),
        .cache_rsp_valid(cache_rsp_valid), .cache_rsp_data(cache_rsp_data),
        .done_valid(done_valid), .done_data(done_data), .done_count(done_count)
    );

    int total = 0;
    int bad = 0;
    int cyc = 0;
    logic [AW-1:0] exp_q[$];
    logic [AW-1:0] warp_addr [L];
    logic outstanding = 1'b0;
    int lat_cnt = 0;
    logic [AW-1:0] held_addr = '0;
    int rdy_ctr = 0;

    function automatic logic [DW-1:0] word_of(logic [AW-1:0] a);
        return {a, a ^ 16'hA5C3};
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    always @(posedge clk) cyc++;

    // cache responder: even address = hit (1 cycle), odd = miss (5 cycles)
    initial begin
        forever begin
            @(negedge clk);
            if (cache_rsp_valid) begin
                cache_rsp_valid = 1'b0;
                outstanding = 1'b0;
            end
            if (outstanding && cache_req_valid)
                chk(1'b0, "R8 request while outstanding", 1, 0);
            if (lat_cnt > 0) begin
                lat_cnt--;
                if (lat_cnt == 0) begin
                    cache_rsp_valid = 1'b1;
                    cache_rsp_data  = word_of(held_addr);
                end
            end else if (!outstanding) begin
                rdy_ctr++;
                cache_req_ready = (rdy_ctr % 3) != 1;
                #1;
                if (cache_req_valid && cache_req_ready) begin
                    if (exp_q.size() == 0) begin
                        chk(1'b0, "R7 unexpected lookup", 64'(cache_req_addr), 0);
                    end else begin
                        logic [AW-1:0] e;
                        e = exp_q.pop_front();
                        chk(cache_req_addr == e, "R3 lookup order", 64'(cache_req_addr), 64'(e));
                    end
                    held_addr = cache_req_addr;
                    outstanding = 1'b1;
                    lat_cnt = cache_req_addr[0] ? 5 : 1;
                end
            end else begin
                cache_req_ready = 1'b0;
            end
        end
    end

    task automatic run_warp(input logic [L-1:0] m);
        int exp_cnt;
        int guard;
        bit busy_bad;
        exp_cnt = 0;
        for (int h = 0; h < 2; h++) begin
            logic [AW-1:0] seen[$];
            seen.delete();
            for (int ln = h * (L/2); ln < (h + 1) * (L/2); ln++) begin
                if (m[ln]) begin
                    bit hit;
                    hit = 0;
                    foreach (seen[s]) if (seen[s] == warp_addr[ln]) hit = 1;
                    if (!hit) begin
                        seen.push_back(warp_addr[ln]);
                        exp_q.push_back(warp_addr[ln]);
                        exp_cnt++;
                    end
                end
            end
        end
        @(negedge clk);
        req_mask = m;
        for (int ln = 0; ln < L; ln++) req_addr[ln*AW +: AW] = warp_addr[ln];
        req_valid = 1'b1;
        chk(req_ready == 1'b1, "R9 ready when idle", 64'(req_ready), 1);
        @(negedge clk);
        req_valid = 1'b0;
        guard = 0;
        busy_bad = 0;
        while (!done_valid && guard < 2000) begin
            if (req_ready) busy_bad = 1;
            @(negedge clk);
            guard++;
        end
        chk(!busy_bad, "R9 ready low while busy", 64'(busy_bad), 0);
        chk(done_valid == 1'b1, "R9 completion seen", 64'(done_valid), 1);
        chk(done_count == CW'(exp_cnt), "R4 lookup count", 64'(done_count), 64'(exp_cnt));
        chk(exp_q.size() == 0, "R4 all lookups issued", 64'(exp_q.size()), 0);
        for (int ln = 0; ln < L; ln++) begin
            logic [DW-1:0] got, want;
            got  = done_data[ln*DW +: DW];
            want = m[ln] ? word_of(warp_addr[ln]) : '0;
            if (m[ln]) chk(got == want, "R5/R10 lane broadcast", 64'(got), 64'(want));
            else       chk(got == want, "R6 inactive lane zero", 64'(got), 64'(want));
        end
        exp_q.delete();
        @(negedge clk);
        chk(done_valid == 1'b0, "R9 single-cycle done", 64'(done_valid), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(req_ready == 1'b1, "R1 reset ready", 64'(req_ready), 1);
        chk(cache_req_valid == 1'b0, "R1 reset no lookup", 64'(cache_req_valid), 0);
        chk(done_valid == 1'b0, "R1 reset no done", 64'(done_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R4: one address everywhere -> one lookup per group
        for (int ln = 0; ln < L; ln++) warp_addr[ln] = 16'h0040;
        run_warp('1);

        // all distinct, mixed parity
        for (int ln = 0; ln < L; ln++) warp_addr[ln] = AW'(16'h0300 + ln * 3);
        run_warp('1);

        // R3: descending addresses with duplicates, both groups share values
        for (int ln = 0; ln < L; ln++) warp_addr[ln] = AW'(16'h0201 - (ln % 5) * 8);
        run_warp('1);

        // R6: sparse mask with duplicates
        for (int ln = 0; ln < L; ln++) warp_addr[ln] = AW'(16'h0100 + (ln % 4));
        run_warp(32'h00F0_A50C);

        // R7: low group empty, then high group empty
        for (int ln = 0; ln < L; ln++) warp_addr[ln] = AW'(16'h0500 + (ln % 6) * 2 + (ln / 8));
        run_warp(32'hFFFF_0000);
        run_warp(32'h0000_FFFF);

        // R7: nothing active
        run_warp('0);

        // R2: high lanes use low-group addresses in reverse
        for (int ln = 0; ln < L; ln++) warp_addr[ln] = AW'(ln < L/2 ? 16'h0700 + ln : 16'h0700 + (L - 1 - ln));
        run_warp(32'hC3C3_5A5A);

        repeat (5) @(negedge clk);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        wait (cyc > 100000);
        bad++;
        total++;
        $display("FAIL watchdog expired actual=%0d expected=done", cyc);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule